// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block turns each read on a simple request/ready bus into a complete read transaction on a serial flash bus with four data pins. Every accepted read frames chip select, shifts out a software-chosen command byte, then one to four address bytes built from the offset of the access, then zero or more dummy bytes, and finally clocks in exactly as many data bytes as the access size asks for. Those bytes come back on the bus packed little-endian into a 32-bit word. The command, address and dummy portions use a single output line. The data portion uses one, two or four input lines. The serial clock is an even division of the system clock in SPI mode 0.

Software sets up five small configuration registers through a write port. A select input picks between this mapped mode and a pass-through mode. In pass-through mode the serial pins follow software-driven inputs, and mapped reads finish at once without touching the bus. The engine copies the configuration at the start of each read, so a write during a transaction only affects later ones.

The controller has the states IDLE, SETUP, CMD, ADDR, DUMMY, DATA, GAP and RESP. These are its transitions:
- IDLE to SETUP on a read in mapped mode, or IDLE to RESP on a read in pass-through mode.
- SETUP to CMD after one half period.
- CMD to ADDR after the eighth command clock.
- ADDR to DUMMY after the last address clock when the dummy count is nonzero, otherwise ADDR to DATA.
- DUMMY to DATA after the last dummy clock.
- DATA to GAP after the last data clock, where chip select is released.
- GAP to RESP after two half periods.
- RESP to IDLE unconditionally.

Top module: `mmflash_rd`

## Requirements
- R1: The first eight serial clocks of every mapped read carry the command byte, MSB first on io0. The command byte is register 0 (reset value 0x03).
- R2: The command is followed by N address bytes, MSB first on io0, where N is register 1 bits [1:0] plus one (reset value 2, so N=3). These bytes hold the low 8*N bits of the bus offset, most significant byte first.
- R3: After the address the engine gives 8*D further serial clocks, where D is register 2 bits [3:0] (0 to 15, reset value 0). D=0 skips this phase entirely.
- R4: The number of data bytes clocked in is 1, 2 or 4 for bus_size 0, 1 or 2, and 3 also gives 4. The first received byte lands in bus_rdata[7:0] and the next bytes fill the higher bytes in order. The bytes above the access size read as zero.
- R5: Chip select goes low with the serial clock low before the first rising edge. It rises after the last falling edge and stays high for at least 2*(H) system cycles. While chip select is high the engine holds the serial clock low.
- R6: Register 3 bits [1:0] set the data lines:
  - code 0 uses one line, sampled on io1.
  - code 1 uses two lines, with io1 carrying the higher bit of each pair.
  - codes 2 and 3 use four lines, with io3 carrying the highest bit.
  Data bits arrive MSB first within each byte.
- R7: While map_en is 0, spi_sck, spi_cs_n and io0 follow sw_sck, sw_cs_n and sw_mosi, and spi_io_oe is 0001. sw_miso always reflects io1. A bus read in this mode gets bus_ready in the cycle after the request is sampled, with data 0, and no chip select activity.
- R8: Each serial half period lasts H = (register 4 bits [3:0]) + 1 system cycles (reset value 1, so H=2). Data changes on falling edges and is sampled on rising edges (mode 0). The bus_ready pulse follows the clock edge that sampled the request by exactly H*(3+2*B) edges, where B is the total number of serial clocks.
- R9: bus_ready is high for exactly one cycle per read, and bus_rdata is valid while it is high.
- R10: A configuration write during a transaction does not alter that transaction. It takes effect on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_en | input | 1 | 1 selects mapped reads, 0 selects pass-through |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register select: 0 command, 1 address length, 2 dummy count, 3 lane code, 4 half period |
| cfg_wdata | input | 8 | Configuration write data |
| bus_req | input | 1 | Read request, held until bus_ready |
| bus_addr | input | ADDR_W | Offset of the read inside the mapped window |
| bus_size | input | 2 | Access size code: 0 one byte, 1 two, 2 or 3 four |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, little-endian |
| sw_sck | input | 1 | Pass-through serial clock |
| sw_cs_n | input | 1 | Pass-through chip select |
| sw_mosi | input | 1 | Pass-through output data |
| sw_miso | output | 1 | Pass-through input data from io1 |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_out | output | 4 | Output values for io3..io0 |
| spi_io_oe | output | 4 | Output enables for io3..io0 |
| spi_io_in | input | 4 | Input values of io3..io0 |

## Verification
Each read result becomes due exactly H*(3+2*B)+1 sampled cycles after the bench raises the request. The bench counts system edges from the request until it sees the ready pulse at a falling clock edge, and compares that count with the formula. It also checks that ready is low again one cycle later. The captured command, the captured address and the number of rising serial edges are compared once chip select has risen. A behavioral flash in the bench captures these values on serial clock edges and drives data on falling edges, so each value is read only after the edge that settles it. Pass-through results are combinational or due one cycle after the request, and they are sampled at the next falling clock edge.

// File: rtl/mmf_pkg.sv
package mmf_pkg;

    localparam int DUMMY_W = 4;
    localparam int HALF_W  = 4;
    localparam int BEAT_W  = DUMMY_W + 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_GAP,
        ST_RESP
    } mmf_state_t;

    typedef struct packed {
        logic [7:0]         opcode;
        logic [1:0]         alen;
        logic [DUMMY_W-1:0] dummy;
        logic [1:0]         lanes;
        logic [HALF_W-1:0]  half;
    } mmf_cfg_t;

    function automatic logic [1:0] lane_log2(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/mmf_cfg.sv
module mmf_cfg
    import mmf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output mmf_cfg_t   cfg_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o.opcode <= 8'h03;
            cfg_o.alen   <= 2'd2;
            cfg_o.dummy  <= '0;
            cfg_o.lanes  <= 2'd0;
            cfg_o.half   <= HALF_W'(1);
        end else if (cfg_we) begin
            case (cfg_addr)
                3'd0:    cfg_o.opcode <= cfg_wdata;
                3'd1:    cfg_o.alen   <= cfg_wdata[1:0];
                3'd2:    cfg_o.dummy  <= cfg_wdata[DUMMY_W-1:0];
                3'd3:    cfg_o.lanes  <= cfg_wdata[1:0];
                3'd4:    cfg_o.half   <= cfg_wdata[HALF_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mmf_clkdiv.sv
module mmf_clkdiv
    import mmf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);

    logic [HALF_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || (cnt_q == half)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: the half-period counter never runs past the latched limit
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= half));

endmodule

// File: rtl/mmf_rxpack.sv
module mmf_rxpack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        sample,
    input  logic [1:0]  lane_code,
    input  logic [3:0]  io_in,
    output logic [31:0] word_o
);

    logic [7:0] sh_q;
    logic [3:0] bitc_q;
    logic [1:0] idx_q;
    logic [3:0] lane_n;
    logic [3:0] bits;
    logic [7:0] sh_next;
    logic [3:0] bitc_next;

    always_comb begin
        case (lane_code)
            2'd0: begin lane_n = 4'd1; bits = {3'b000, io_in[1]};   end
            2'd1: begin lane_n = 4'd2; bits = {2'b00, io_in[1:0]};  end
            default: begin lane_n = 4'd4; bits = io_in;             end
        endcase
        sh_next   = (sh_q << lane_n) | {4'b0000, bits};
        bitc_next = bitc_q + lane_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bitc_q <= '0;
            idx_q  <= '0;
            word_o <= '0;
        end else if (clear) begin
            sh_q   <= '0;
            bitc_q <= '0;
            idx_q  <= '0;
            word_o <= '0;
        end else if (sample) begin
            if (bitc_next == 4'd8) begin
                for (int b = 0; b < 4; b++) begin
                    if (idx_q == 2'(b)) word_o[8*b +: 8] <= sh_next;
                end
                idx_q  <= idx_q + 1'b1;
                bitc_q <= '0;
                sh_q   <= '0;
            end else begin
                sh_q   <= sh_next;
                bitc_q <= bitc_next;
            end
        end
    end

    // R4: a new read starts from an all-zero word so unused bytes read zero
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (word_o == 32'h0));

    // R6: a byte never collects more than eight bits
    p_byte_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (bitc_q < 4'd8));

endmodule

// File: rtl/mmf_ctrl.sv
module mmf_ctrl
    import mmf_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_en,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  mmf_cfg_t          cfg_i,
    input  logic              tick,
    output logic              run,
    output logic [HALF_W-1:0] half_o,
    output logic [1:0]        lane_o,
    output logic              sample,
    output logic              rx_clear,
    output logic              bus_ready,
    output logic              sck_o,
    output logic              cs_n_o,
    output logic              io0_o,
    output logic              oe0_o
);

    mmf_state_t        state_q, state_d;
    mmf_cfg_t          lat_q;
    logic [39:0]       tx_q;
    logic [BEAT_W-1:0] bc_q;
    logic [2:0]        nbytes_q;
    logic              sck_q, cs_nq, gap_q;

    logic              accept, shift_st, rise, fall, last;
    logic [2:0]        nbytes;
    logic [31:0]       addr32, addr_al;
    logic [4:0]        al_sh;
    logic [BEAT_W-1:0] abeats, dbeats, datbeats;

    assign accept   = (state_q == ST_IDLE) && bus_req;
    assign shift_st = state_q inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA};
    assign rise     = tick && shift_st && !sck_q;
    assign fall     = tick && shift_st && sck_q;
    assign last     = fall && (bc_q == '0);

    always_comb begin
        case (bus_size)
            2'd0:    nbytes = 3'd1;
            2'd1:    nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
        addr32   = 32'(bus_addr);
        al_sh    = {2'd3 - cfg_i.alen, 3'b000};
        addr_al  = addr32 << al_sh;
        abeats   = BEAT_W'({1'b0, lat_q.alen} + 3'd1) << 3;
        dbeats   = BEAT_W'(lat_q.dummy) << 3;
        datbeats = (BEAT_W'(nbytes_q) << 3) >> lane_log2(lat_q.lanes);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (bus_req) state_d = map_en ? ST_SETUP : ST_RESP;
            ST_SETUP: if (tick) state_d = ST_CMD;
            ST_CMD:   if (last) state_d = ST_ADDR;
            ST_ADDR:  if (last) state_d = (lat_q.dummy != '0) ? ST_DUMMY : ST_DATA;
            ST_DUMMY: if (last) state_d = ST_DATA;
            ST_DATA:  if (last) state_d = ST_GAP;
            ST_GAP:   if (tick && gap_q) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q    <= '0;
            tx_q     <= '0;
            bc_q     <= '0;
            nbytes_q <= '0;
            sck_q    <= 1'b0;
            cs_nq    <= 1'b1;
            gap_q    <= 1'b0;
        end else begin
            if (accept) begin
                lat_q    <= cfg_i;
                nbytes_q <= nbytes;
                tx_q     <= {cfg_i.opcode, addr_al};
                bc_q     <= BEAT_W'(8);
                cs_nq    <= !map_en;
                gap_q    <= 1'b0;
            end
            if (rise) begin
                sck_q <= 1'b1;
                bc_q  <= bc_q - 1'b1;
            end
            if (fall) begin
                sck_q <= 1'b0;
                if (state_q inside {ST_CMD, ST_ADDR}) tx_q <= tx_q << 1;
                if (bc_q == '0) begin
                    case (state_q)
                        ST_CMD:   bc_q  <= abeats;
                        ST_ADDR:  bc_q  <= (lat_q.dummy != '0) ? dbeats : datbeats;
                        ST_DUMMY: bc_q  <= datbeats;
                        ST_DATA:  cs_nq <= 1'b1;
                        default:  ;
                    endcase
                end
            end
            if ((state_q == ST_GAP) && tick) gap_q <= !gap_q;
        end
    end

    assign run       = !(state_q inside {ST_IDLE, ST_RESP});
    assign half_o    = lat_q.half;
    assign lane_o    = lat_q.lanes;
    assign sample    = rise && (state_q == ST_DATA);
    assign rx_clear  = accept;
    assign bus_ready = (state_q == ST_RESP);
    assign sck_o     = sck_q;
    assign cs_n_o    = cs_nq;
    assign io0_o     = tx_q[39];
    assign oe0_o     = state_q inside {ST_SETUP, ST_CMD, ST_ADDR};

    // R5: the serial clock rests low whenever chip select is released
    p_cs_sck_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_nq |-> !sck_q);

    // R5: a released chip select stays high for more than one cycle
    p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_nq) |=> cs_nq);

    // R7: a read in pass-through mode never lowers chip select
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && bus_req && !map_en) |=> cs_nq);

    // R9: the ready strobe lasts one cycle
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // R10: the copied configuration holds for the whole transaction
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE)) |-> $stable(lat_q));

endmodule

// File: rtl/mmflash_rd.sv
module mmflash_rd
    import mmf_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_en,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    input  logic              sw_sck,
    input  logic              sw_cs_n,
    input  logic              sw_mosi,
    output logic              sw_miso,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic [3:0]        spi_io_out,
    output logic [3:0]        spi_io_oe,
    input  logic [3:0]        spi_io_in
);

    mmf_cfg_t          cfg;
    logic              run, tick, sample, rx_clear;
    logic [HALF_W-1:0] half;
    logic [1:0]        lane;
    logic              e_sck, e_cs_n, e_io0, e_oe0;

    mmf_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg)
    );

    mmf_clkdiv u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .half  (half),
        .tick  (tick)
    );

    mmf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_en    (map_en),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .cfg_i     (cfg),
        .tick      (tick),
        .run       (run),
        .half_o    (half),
        .lane_o    (lane),
        .sample    (sample),
        .rx_clear  (rx_clear),
        .bus_ready (bus_ready),
        .sck_o     (e_sck),
        .cs_n_o    (e_cs_n),
        .io0_o     (e_io0),
        .oe0_o     (e_oe0)
    );

    mmf_rxpack u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_clear),
        .sample    (sample),
        .lane_code (lane),
        .io_in     (spi_io_in),
        .word_o    (bus_rdata)
    );

    assign spi_sck    = map_en ? e_sck  : sw_sck;
    assign spi_cs_n   = map_en ? e_cs_n : sw_cs_n;
    assign spi_io_out = {3'b000, map_en ? e_io0 : sw_mosi};
    assign spi_io_oe  = {3'b000, map_en ? e_oe0 : 1'b1};
    assign sw_miso    = spi_io_in[1];

endmodule

// File: tb/mmflash_rd_bench.sv
`timescale 1ns/1ps
module mmflash_rd_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        bus_req = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        sw_sck = 1'b0, sw_cs_n = 1'b1, sw_mosi = 1'b0;
    logic        sw_miso;
    logic        spi_sck, spi_cs_n;
    logic [3:0]  spi_io_out, spi_io_oe;
    logic [3:0]  fl_io = 4'h0;

    always #2.5 clk = ~clk;

    mmflash_rd u_mmflash_rd (
        .clk(clk), .rst_n(rst_n), .map_en(map_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .sw_sck(sw_sck), .sw_cs_n(sw_cs_n), .sw_mosi(sw_mosi), .sw_miso(sw_miso),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe), .spi_io_in(fl_io)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] memv(input longint a);
        return 8'((a * 37) + (a >> 5) + 11);
    endfunction

    // model configuration (what the flash expects on the wire)
    int m_nab = 3, m_nd = 0, m_L = 1, m_H = 2;
    int exp_gap = 2;

    // behavioral flash
    int          fl_rise = 0;
    logic [39:0] fl_sh = '0;
    int          fl_rises_done = 0;
    int          fl_op = 0;
    longint      fl_adr = 0;
    int          cs_falls = 0;

    always @(negedge spi_cs_n) begin
        fl_rise = 0;
        fl_sh   = '0;
        cs_falls++;
        chk(spi_sck == 1'b0, "R5", "sck at cs fall", spi_sck, 0);
    end

    always @(posedge spi_cs_n) begin
        fl_rises_done = fl_rise;
        fl_op  = int'(8'(fl_sh >> (8 * m_nab)));
        fl_adr = longint'(fl_sh & ((40'd1 << (8 * m_nab)) - 40'd1));
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (fl_rise < 8 + 8 * m_nab) fl_sh = {fl_sh[38:0], spi_io_out[0]};
            fl_rise++;
        end
    end

    always @(negedge spi_sck) begin
        int pre, k, bp, j, off;
        logic [7:0] b;
        logic [3:0] v;
        longint a;
        pre = 8 + 8 * m_nab + 8 * m_nd;
        if (!spi_cs_n && fl_rise >= pre) begin
            k   = fl_rise - pre;
            bp  = k * m_L;
            j   = bp / 8;
            off = bp % 8;
            a   = longint'(fl_sh & ((40'd1 << (8 * m_nab)) - 40'd1));
            b   = memv(a + j);
            v   = 4'((b >> (8 - off - m_L)) & ((1 << m_L) - 1));
            if (m_L == 1)      fl_io = {2'b00, v[0], 1'b0};
            else if (m_L == 2) fl_io = {2'b00, v[1:0]};
            else               fl_io = v;
        end
    end

    // R5: chip-select high time between transactions
    int cs_high_run = 1000;
    logic cs_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n) cs_high_run++;
            else begin
                if (cs_prev) chk(cs_high_run >= exp_gap, "R5", "cs high gap", cs_high_run, exp_gap);
                cs_high_run = 0;
            end
            cs_prev = spi_cs_n;
        end
    end

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int op, input int nab, input int nd, input int lc, input int half);
        cfg_write(3'd0, 8'(op));
        cfg_write(3'd1, 8'(nab - 1));
        cfg_write(3'd2, 8'(nd));
        cfg_write(3'd3, 8'(lc));
        cfg_write(3'd4, 8'(half));
        m_nab = nab; m_nd = nd; m_L = (lc == 0) ? 1 : (lc == 1) ? 2 : 4; m_H = half + 1;
    endtask

    task automatic do_read(input logic [23:0] a, input logic [1:0] sz,
                           output logic [31:0] data, output int n);
        @(negedge clk);
        bus_req = 1'b1; bus_addr = a; bus_size = sz; n = 0;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            if (bus_ready) break;
            if (n > 20000) begin
                chk(0, "R9", "ready timeout", n, 0);
                break;
            end
        end
        data = bus_rdata;
        bus_req = 1'b0;
        @(negedge clk);
        chk(bus_ready == 1'b0, "R9", "ready one cycle", bus_ready, 0);
    endtask

    task automatic txn(input int op, input logic [23:0] a, input logic [1:0] sz);
        logic [31:0] data, expw;
        int n, nb, beats, lat;
        longint amask;
        do_read(a, sz, data, n);
        nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        expw = 32'h0;
        for (int j = 0; j < nb; j++) expw[8*j +: 8] = memv(longint'(a & ((1 << (8 * m_nab)) - 1)) + j);
        beats = 8 + 8 * m_nab + 8 * m_nd + (8 * nb) / m_L;
        lat = m_H * (3 + 2 * beats) + 1;
        amask = (longint'(1) << (8 * m_nab)) - 1;
        chk(data == expw, "R4", "read data (R6 lanes)", data, expw);
        chk(fl_op == op, "R1", "command byte", fl_op, op);
        chk(fl_adr == (longint'(a) & amask), "R2", "address bytes", fl_adr, longint'(a) & amask);
        chk(fl_rises_done == beats, "R3", "serial clock count", fl_rises_done, beats);
        chk(n == lat, "R8", "ready latency", n, lat);
        exp_gap = 2 * m_H;
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int iter;
        logic [31:0] d;
        int n, f0;
        repeat (5) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R7", "reset cs via passthrough", spi_cs_n, 1);
        rst_n = 1'b1;
        map_en = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R5", "reset cs high", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R8", "reset sck low", spi_sck, 0);
        chk(bus_ready == 1'b0, "R9", "reset ready low", bus_ready, 0);

        // reset configuration: opcode 03, 3 address bytes, no dummy, one lane, H=2
        txn(8'h03, 24'h123456, 2'd2);

        iter = 0;
        for (int half = 0; half < 2; half++)
            for (int lc = 0; lc < 4; lc++)
                for (int nab = 1; nab <= 4; nab++)
                    for (int nd = 0; nd < 3; nd++) begin
                        setup(8'(8'h0B + iter), nab, nd, lc, half);
                        for (int sz = 0; sz < 4; sz++) begin
                            txn(8'(8'h0B + iter), 24'((iter * 24'h1357 + sz * 24'h0A5 + 24'h0F0) & 24'hFFFFFF), 2'(sz));
                        end
                        iter++;
                    end

        // R10: a write during a transaction affects only the next one
        setup(8'h3B, 2, 1, 1, 1);
        fork
            txn(8'h3B, 24'h00ABCD, 2'd1);
            begin
                repeat (30) @(negedge clk);
                cfg_write(3'd0, 8'hC5);
            end
        join
        txn(8'hC5, 24'h001234, 2'd0);
        chk(fl_op == 8'hC5, "R10", "new opcode on next read", fl_op, 8'hC5);

        // R7: pass-through
        map_en = 1'b0;
        sw_cs_n = 1'b1; sw_sck = 1'b1; sw_mosi = 1'b1;
        fl_io = 4'b0010;
        @(negedge clk);
        chk(spi_sck == 1'b1, "R7", "sck follows sw", spi_sck, 1);
        chk(spi_io_out[0] == 1'b1, "R7", "io0 follows sw", spi_io_out[0], 1);
        chk(spi_io_oe == 4'b0001, "R7", "oe in passthrough", spi_io_oe, 1);
        chk(sw_miso == 1'b1, "R7", "miso from io1", sw_miso, 1);
        sw_cs_n = 1'b0; sw_sck = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1'b0, "R7", "cs follows sw", spi_cs_n, 0);
        chk(spi_sck == 1'b0, "R7", "sck follows sw low", spi_sck, 0);
        sw_cs_n = 1'b1;
        @(negedge clk);
        f0 = cs_falls;
        do_read(24'h000777, 2'd2, d, n);
        chk(n == 1, "R7", "passthrough read latency", n, 1);
        chk(d == 32'h0, "R7", "passthrough read data", d, 0);
        chk(cs_falls == f0, "R7", "no cs activity", cs_falls, f0);
        map_en = 1'b1;
        @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule